// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block is the instruction front end of one multithreaded processor core. Every resident warp owns a single buffer slot that holds its next instruction. The instruction has one destination register index and two source register indices. A fetch arbiter picks one active warp with an empty slot in each cycle and requests an instruction for it. The slot is filled when the instruction memory side acknowledges the request.

A per-warp register scoreboard records which registers still wait for a result. A buffered instruction may issue only when none of its three registers is pending. Issue opportunities come once every four cycles. At each opportunity a round-robin arbiter picks one eligible warp, starting after the warp that issued most recently. Moving from one warp to another costs no cycles.

When an instruction issues, its destination is marked pending and its slot is freed. A later writeback for that warp and register clears the pending mark.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, every slot is empty, every register is ready, `issue_valid` is low, and the issue cadence starts at phase 0 in the first cycle out of reset.
- R2: In any cycle at most one fetch is requested. `fetch_req` is high exactly when some active warp has an empty slot. `fetch_warp` is the first such warp in ascending circular order after the warp that was last fetched, and warp 0 is searched first after reset.
- R3: When `fetch_req` and `fetch_ack` are both high at a clock edge, the slot of `fetch_warp` captures `fetch_dst`, `fetch_src0` and `fetch_src1`. Without `fetch_ack` nothing is captured, the fetch pointer does not move, and the request repeats.
- R4: Issue decisions are made only at the edge ending a cycle whose phase is 0, where the phase counts 0,1,2,3 from reset. `issue_valid` is therefore high only in the cycles 1, 5, 9, ... counted from the first cycle out of reset, and never in two cycles closer than four apart.
- R5: A warp is eligible only when it is active, its slot holds an instruction, and its destination and both sources are all not pending in that warp's scoreboard.
- R6: A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears that register's pending mark at the clock edge. The change takes effect for decisions made in the following cycles.
- R7: On issue, the destination register of the issuing warp becomes pending and its slot becomes empty, both at the same edge.
- R8: Among eligible warps, the winner is the first in ascending circular order after the most recently issued warp. Warp 0 is first after reset.
- R9: An opportunity with no eligible warp passes idle, and the cadence of later opportunities is unchanged.
- R10: In the cycle after a decision, `issue_warp`, `issue_dst`, `issue_src0` and `issue_src1` carry the winning warp and its buffered instruction.
- R11: Inactive warps are neither fetched nor issued, and any instruction already in their slot is kept until the warp is active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_active | input | NUM_WARPS | One bit per resident warp, high when the warp is active |
| fetch_req | output | 1 | A fetch is requested this cycle |
| fetch_warp | output | WARP_IW | Warp the fetch is for |
| fetch_ack | input | 1 | Instruction fields are valid, so fill the slot |
| fetch_dst | input | REG_IW | Destination register index of the fetched instruction |
| fetch_src0 | input | REG_IW | First source register index |
| fetch_src1 | input | REG_IW | Second source register index |
| wb_valid | input | 1 | A register result is written back |
| wb_warp | input | WARP_IW | Warp of the writeback |
| wb_reg | input | REG_IW | Register made ready |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WARP_IW | Issuing warp |
| issue_dst | output | REG_IW | Destination of the issued instruction |
| issue_src0 | output | REG_IW | First source of the issued instruction |
| issue_src1 | output | REG_IW | Second source of the issued instruction |

## Verification
The assertions assume that a writeback names only a register that is currently pending, so a clear never meets a set of the same bit. They also assume `fetch_ack` is sampled only together with a request. The stimulus follows these rules by design. The bench picks writeback targets only from the pending set of its own model, and it drives `fetch_ack` as a plain random bit that the block ignores when no request is made.

The random phases narrow the register indices so that dependencies, write-after-write stalls and idle opportunities occur often. Directed phases cover the case with no warp active and the case with only one warp active.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int DEF_WARPS = 24;
  localparam int DEF_REGS  = 16;
  localparam int DEF_GAP   = 4;
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N = wis_pkg::DEF_WARPS,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  int c;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    c     = 0;
    for (int i = 1; i <= N; i++) begin
      c = int'(last) + i;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int W = wis_pkg::DEF_WARPS,
  parameter int R = wis_pkg::DEF_REGS,
  localparam int WIW = $clog2(W),
  localparam int RIW = $clog2(R)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [WIW-1:0]       set_warp,
  input  logic [RIW-1:0]       set_reg,
  input  logic                 clr_en,
  input  logic [WIW-1:0]       clr_warp,
  input  logic [RIW-1:0]       clr_reg,
  output logic [W-1:0][R-1:0]  pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      if (clr_en) pend[clr_warp][clr_reg] <= 1'b0;
      if (set_en) pend[set_warp][set_reg] <= 1'b1;
    end
  end

  // R6: a writeback that does not collide with an issue leaves the register ready
  a_r6_wb_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_warp == clr_warp && set_reg == clr_reg))
    |=> !pend[$past(clr_warp)][$past(clr_reg)]);
endmodule

// File: rtl/wis_slot_buf.sv
module wis_slot_buf #(
  parameter int W = wis_pkg::DEF_WARPS,
  parameter int R = wis_pkg::DEF_REGS,
  localparam int WIW = $clog2(W),
  localparam int RIW = $clog2(R)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [WIW-1:0]        wr_warp,
  input  logic [RIW-1:0]        wr_dst,
  input  logic [RIW-1:0]        wr_s0,
  input  logic [RIW-1:0]        wr_s1,
  input  logic                  free_en,
  input  logic [WIW-1:0]        free_warp,
  output logic [W-1:0]          valid,
  output logic [W-1:0][RIW-1:0] dst,
  output logic [W-1:0][RIW-1:0] s0,
  output logic [W-1:0][RIW-1:0] s1
);
  always_ff @(posedge clk) begin
    if (wr_en) begin
      dst[wr_warp] <= wr_dst;
      s0[wr_warp]  <= wr_s0;
      s1[wr_warp]  <= wr_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      if (free_en) valid[free_warp] <= 1'b0;
      if (wr_en)   valid[wr_warp]   <= 1'b1;
    end
  end

  // R3: a write lands in an empty slot only
  a_r3_fill_empty: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !valid[wr_warp]);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = wis_pkg::DEF_WARPS,
  parameter int NUM_REGS  = wis_pkg::DEF_REGS,
  parameter int ISSUE_GAP = wis_pkg::DEF_GAP,
  localparam int WARP_IW  = $clog2(NUM_WARPS),
  localparam int REG_IW   = $clog2(NUM_REGS),
  localparam int PH_W     = $clog2(ISSUE_GAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_active,
  output logic                 fetch_req,
  output logic [WARP_IW-1:0]   fetch_warp,
  input  logic                 fetch_ack,
  input  logic [REG_IW-1:0]    fetch_dst,
  input  logic [REG_IW-1:0]    fetch_src0,
  input  logic [REG_IW-1:0]    fetch_src1,
  input  logic                 wb_valid,
  input  logic [WARP_IW-1:0]   wb_warp,
  input  logic [REG_IW-1:0]    wb_reg,
  output logic                 issue_valid,
  output logic [WARP_IW-1:0]   issue_warp,
  output logic [REG_IW-1:0]    issue_dst,
  output logic [REG_IW-1:0]    issue_src0,
  output logic [REG_IW-1:0]    issue_src1
);
  logic [NUM_WARPS-1:0]              slot_valid;
  logic [NUM_WARPS-1:0][REG_IW-1:0]  slot_dst, slot_s0, slot_s1;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend;
  logic [NUM_WARPS-1:0]              elig;
  logic [PH_W-1:0]                   phase;
  logic [WARP_IW-1:0]                last_fetch, last_issue;
  logic                              pick_found;
  logic [WARP_IW-1:0]                pick_idx;
  logic                              opp, do_issue, do_fill;

  assign opp      = (phase == '0);
  assign do_issue = opp && pick_found;
  assign do_fill  = fetch_req && fetch_ack;

  // Eligibility: active, buffered, and no pending operand or destination
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
    assign elig[w] = warp_active[w] && slot_valid[w]
                   && !pend[w][slot_s0[w]] && !pend[w][slot_s1[w]]
                   && !pend[w][slot_dst[w]];
  end

  wis_rr_pick #(.N(NUM_WARPS)) u_fetch_pick (
    .req(warp_active & ~slot_valid), .last(last_fetch),
    .found(fetch_req), .idx(fetch_warp));

  wis_rr_pick #(.N(NUM_WARPS)) u_issue_pick (
    .req(elig), .last(last_issue),
    .found(pick_found), .idx(pick_idx));

  wis_slot_buf #(.W(NUM_WARPS), .R(NUM_REGS)) u_slots (
    .clk(clk), .rst(rst),
    .wr_en(do_fill), .wr_warp(fetch_warp),
    .wr_dst(fetch_dst), .wr_s0(fetch_src0), .wr_s1(fetch_src1),
    .free_en(do_issue), .free_warp(pick_idx),
    .valid(slot_valid), .dst(slot_dst), .s0(slot_s0), .s1(slot_s1));

  wis_scoreboard #(.W(NUM_WARPS), .R(NUM_REGS)) u_sb (
    .clk(clk), .rst(rst),
    .set_en(do_issue), .set_warp(pick_idx), .set_reg(slot_dst[pick_idx]),
    .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg),
    .pend(pend));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= '0;
      last_fetch  <= WARP_IW'(NUM_WARPS - 1);
      last_issue  <= WARP_IW'(NUM_WARPS - 1);
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_dst   <= '0;
      issue_src0  <= '0;
      issue_src1  <= '0;
    end else begin
      phase <= (phase == PH_W'(ISSUE_GAP - 1)) ? '0 : phase + 1'b1;
      if (do_fill) last_fetch <= fetch_warp;
      issue_valid <= do_issue;
      if (do_issue) begin
        last_issue <= pick_idx;
        issue_warp <= pick_idx;
        issue_dst  <= slot_dst[pick_idx];
        issue_src0 <= slot_s0[pick_idx];
        issue_src1 <= slot_s1[pick_idx];
      end
    end
  end

  // R4: issues are never closer than four cycles apart
  a_r4_issue_spacing: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !$past(issue_valid) && !$past(issue_valid, 2) && !$past(issue_valid, 3));
  // R7: an issued destination is pending and its slot is empty
  a_r7_dst_pending: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> pend[issue_warp][issue_dst]);
  a_r7_slot_freed: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !slot_valid[issue_warp]);
  // R2: a fetch targets an active warp with an empty slot
  a_r2_fetch_legal: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> warp_active[fetch_warp] && !slot_valid[fetch_warp]);
  // R11: the issuing warp was active at its decision
  a_r11_issue_active: assert property (@(posedge clk) disable iff (rst)
    do_issue |-> warp_active[pick_idx]);
endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW = 24;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0] warp_active = '1;
  logic fetch_req, fetch_ack = 1'b0;
  logic [4:0] fetch_warp;
  logic [3:0] fetch_dst = '0, fetch_src0 = '0, fetch_src1 = '0;
  logic wb_valid = 1'b0;
  logic [4:0] wb_warp = '0;
  logic [3:0] wb_reg = '0;
  logic issue_valid;
  logic [4:0] issue_warp;
  logic [3:0] issue_dst, issue_src0, issue_src1;

  always #2 clk = ~clk;

  warp_issue_sched dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model state
  bit m_sv[NW];
  bit [3:0] m_dst[NW], m_s0[NW], m_s1[NW];
  bit m_pend[NW][NR];
  int m_lf, m_li, m_phase;
  bit m_iv;
  int m_iw;
  bit [3:0] m_id, m_i0, m_i1;
  bit narrow = 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rr(bit [NW-1:0] req, int last);
    for (int i = 1; i <= NW; i++) begin
      int c = (last + i) % NW;
      if (req[c]) return c;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < NW; w++) begin
      m_sv[w] = 0;
      for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
    end
    m_lf = NW - 1; m_li = NW - 1; m_phase = 0; m_iv = 0;
  endtask

  // one cycle, entered at a falling edge
  task automatic step(bit do_wb);
    bit [NW-1:0] freq, elig;
    int fr, ir, wbw, wbr;
    bit wbv;
    // R4 R5 R8 R9 R10: registered issue outputs
    chk(issue_valid == m_iv, "R4 R9 issue_valid", issue_valid, m_iv);
    if (m_iv && issue_valid) begin
      chk(issue_warp == m_iw, "R8 issue_warp", issue_warp, m_iw);
      chk(issue_dst == m_id, "R10 issue_dst", issue_dst, m_id);
      chk({issue_src0, issue_src1} == {m_i0, m_i1}, "R3 R10 issue_src", {issue_src0, issue_src1}, {m_i0, m_i1});
    end
    // drive inputs
    fetch_ack  = ($urandom % 4) != 0;
    fetch_dst  = narrow ? 4'($urandom % 4) : 4'($urandom);
    fetch_src0 = narrow ? 4'($urandom % 4) : 4'($urandom);
    fetch_src1 = narrow ? 4'($urandom % 4) : 4'($urandom);
    wbv = 0; wbw = 0; wbr = 0;
    if (do_wb && ($urandom % 2)) begin
      int start = $urandom % (NW * NR);
      for (int k = 0; k < NW * NR; k++) begin
        int x = (start + k) % (NW * NR);
        if (!wbv && m_pend[x / NR][x % NR]) begin
          wbv = 1; wbw = x / NR; wbr = x % NR;
        end
      end
    end
    wb_valid = wbv; wb_warp = 5'(wbw); wb_reg = 4'(wbr);
    #1;
    // R2 R11: fetch request
    for (int w = 0; w < NW; w++) freq[w] = warp_active[w] && !m_sv[w];
    fr = rr(freq, m_lf);
    chk(fetch_req == (fr >= 0), "R2 R11 fetch_req", fetch_req, fr >= 0);
    if (fr >= 0 && fetch_req) chk(fetch_warp == fr, "R2 fetch_warp", fetch_warp, fr);
    // model next state
    for (int w = 0; w < NW; w++)
      elig[w] = warp_active[w] && m_sv[w] && !m_pend[w][m_s0[w]]
                && !m_pend[w][m_s1[w]] && !m_pend[w][m_dst[w]];
    ir = (m_phase == 0) ? rr(elig, m_li) : -1;
    m_iv = (ir >= 0);
    if (wbv) m_pend[wbw][wbr] = 0;   // R6
    if (ir >= 0) begin               // R7
      m_iw = ir; m_id = m_dst[ir]; m_i0 = m_s0[ir]; m_i1 = m_s1[ir];
      m_pend[ir][m_dst[ir]] = 1;
      m_sv[ir] = 0;
      m_li = ir;
    end
    if (fr >= 0 && fetch_ack) begin  // R3
      m_sv[fr] = 1; m_dst[fr] = fetch_dst; m_s0[fr] = fetch_src0; m_s1[fr] = fetch_src1;
      m_lf = fr;
    end
    m_phase = (m_phase + 1) % 4;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    chk(issue_valid == 0, "R1 issue_valid after reset", issue_valid, 0);
    #1;
    chk(fetch_req == 1 && fetch_warp == 0, "R1 fetch starts at warp 0", fetch_warp, 0);
    #0;
    @(negedge clk);
    // the model must see this cycle too: restart cleanly with a new reset
    rst = 1'b1; @(negedge clk); model_reset(); rst = 1'b0;
    // all warps active, dependent narrow register use
    repeat (400) step(1);
    // R11: nothing active, no fetch and no issue
    warp_active = '0;
    repeat (40) step(1);
    // R9: one warp, writebacks withheld so opportunities go idle
    warp_active = 24'h000020;
    repeat (40) step(0);
    repeat (200) step(1);
    // R11: slots kept across deactivation, then restored
    warp_active = 24'h0F0F0F;
    repeat (60) step(0);
    warp_active = '1;
    repeat (100) step(1);
    // random masks and wider register indices
    for (int blk = 0; blk < 30; blk++) begin
      narrow = (blk % 3) != 0;
      warp_active = (blk % 5 == 0) ? '1 : NW'($urandom | $urandom);
      repeat (100) step(($urandom % 8) != 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule